// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block runs an external sample-and-hold and analog-to-digital converter through a short handshake. Software programs two byte-wide registers over a simple write port. The configuration register holds an enable bit, a divider code and a settling code. The control register holds a starting channel, a four-channel scan selector, a continuous-run selector and a start bit.

Once started, the block settles for a programmed number of conversion-clock periods. It then raises a one-cycle convert request with the channel number and waits for the converter's done pulse. It stores each returned 10-bit result in a per-channel result register, which can be read back at any time.

In single and scan modes the start bit drops by itself when the work is finished. In continuous mode the start bit stays set until software clears it. The sequence then stops cleanly after the conversion already in flight.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset both register read-backs are 0x00, `busy` is 0 and `conv_req` is 0.
- R2: The control read-back packs the channel in bits 2:0, the continuous bit in bit 4, the scan bit in bit 5 and START in bit 7. Bits 3 and 6 always read 0.
- R3: Configuration layout:
  - Divider code: bits 2:0. It gives a ratio of 2^code system clocks per conversion clock; codes 6 and 7 act as code 5 (ratio 32).
  - Settling code: bits 5:3. It gives 2^code conversion-clock periods; code 7 acts as code 6 (64).
  - Bit 6 reads 0. Bit 7 is the enable.
  - The convert request rises exactly ratio×settle system cycles after the clock edge that accepts START, and the same interval after the edge that accepts a done pulse that leads to another conversion.
- R4: While enable is 1, a configuration write changes only the enable bit. The divider and settling codes keep their values.
- R5: A control write with bit 7 set starts a sequence only while `busy` is 0 and enable is 1. With enable at 0 the other fields load, START stays 0 and `busy` stays 0.
- R6: A single conversion (scan 0, continuous 0) converts the chosen channel once. It then clears START and drops `busy` on the edge that accepts the done pulse.
- R7: With scan set, four conversions run on channels first, first+1, first+2, first+3 modulo 8. For example, a start of 6 gives 6, 7, 0, 1.
- R8: Continuous mode behaviour:
  - The block restarts the same single conversion or burst after each completes, and START stays set.
  - A control write that clears START lets the in-flight conversion finish. The block then goes idle.
- R9: `conv_req` lasts one cycle and `chan_sel` names the channel being converted. A done pulse is accepted only after a request and before its done. At any other time it is ignored.
- R10: Each accepted result is written to the result register of the channel converted and appears on `rd_data` when `rd_chan` selects that channel.
- R11: While `busy` is 1, control writes leave the channel, scan and continuous fields unchanged. They can only clear START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects control, 1 selects configuration |
| wr_data | input | 8 | Write data |
| ctrl_rd | output | 8 | Control register read-back |
| cfg_rd | output | 8 | Configuration register read-back |
| rd_chan | input | 3 | Result register select |
| rd_data | output | 10 | Selected stored result |
| chan_sel | output | 3 | Channel for the converter multiplexer |
| cclk_en | output | 1 | Divided conversion-clock enable (during settling) |
| conv_req | output | 1 | One-cycle convert request |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 10 | Converter result, valid with done |
| busy | output | 1 | Sequence in progress |

## Verification
A behavioural model in the bench follows every cycle with a countdown of ratio×settle cycles, and the outputs are compared on every clock.

The mode patterns are chosen to separate the behaviours:
- Single conversion on two channels shows that START clears itself.
- A scan starting at channel 6 shows the modulo-8 wrap and the four-step order.
- A continuous run with a later clear separates a START that stays held from one that self-clears, and shows the clean stop.

Timing and boundary patterns:
- The convert-request latency is measured at ratio 2 with 4 settling periods, and again with a reserved divider code that must clamp to 32.
- Writes made while enabled or busy, a start attempted with the enable off, and a spurious done pulse during settling show which inputs must be ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_W         = 3;
    localparam int BURST_LEN    = 4;
    localparam int DIV_LOG2_MAX = 5;
    localparam int DLY_LOG2_MAX = 6;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SETTLE,
        S_REQ,
        S_WAIT
    } seq_state_t;

    typedef struct packed {
        logic            start;
        logic            rsv6;
        logic            scan;
        logic            cont;
        logic            rsv3;
        logic [CH_W-1:0] chan;
    } ctrl_reg_t;

    typedef struct packed {
        logic       enable;
        logic       rsv6;
        logic [2:0] dly;
        logic [2:0] div;
    } cfg_reg_t;

    function automatic logic [2:0] div_log2(input logic [2:0] code);
        return (code > 3'(DIV_LOG2_MAX)) ? 3'(DIV_LOG2_MAX) : code;
    endfunction

    function automatic logic [2:0] dly_log2(input logic [2:0] code);
        return (code > 3'(DLY_LOG2_MAX)) ? 3'(DLY_LOG2_MAX) : code;
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int CNT_W = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] log2,
    output logic       tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim  = CNT_W'((32'd1 << log2) - 32'd1);
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CW     = CH_W,
    parameter int BURST  = BURST_LEN,
    parameter int DCNT_W = DLY_LOG2_MAX
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [CW-1:0] go_chan,
    input  logic          go_scan,
    input  logic          start,
    input  logic          cont,
    input  logic          scan,
    input  logic [CW-1:0] first_chan,
    input  logic          tick,
    input  logic [2:0]    settle_log2,
    input  logic          done,
    output logic          conv_req,
    output logic          busy,
    output logic          settling,
    output logic          store,
    output logic          seq_end,
    output logic [CW-1:0] cur_chan
);
    localparam int LEFT_W = $clog2(BURST + 1);

    seq_state_t        state;
    logic [LEFT_W-1:0] left;
    logic [DCNT_W-1:0] dcnt;
    logic [DCNT_W-1:0] dlim;

    assign dlim     = DCNT_W'((32'd1 << settle_log2) - 32'd1);
    assign conv_req = (state == S_REQ);
    assign busy     = (state != S_IDLE);
    assign settling = (state == S_SETTLE);
    assign store    = (state == S_WAIT) && done;
    assign seq_end  = store && (!start || (left <= LEFT_W'(1) && !cont));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            cur_chan <= '0;
            left     <= '0;
            dcnt     <= '0;
        end else begin
            case (state)
                S_IDLE: if (go) begin
                    cur_chan <= go_chan;
                    left     <= go_scan ? LEFT_W'(BURST) : LEFT_W'(1);
                    dcnt     <= '0;
                    state    <= S_SETTLE;
                end
                S_SETTLE: if (tick) begin
                    if (dcnt == dlim) state <= S_REQ;
                    else              dcnt  <= dcnt + 1'b1;
                end
                S_REQ: state <= S_WAIT;
                S_WAIT: if (done) begin
                    dcnt <= '0;
                    if (!start) begin
                        state <= S_IDLE;
                    end else if (left > LEFT_W'(1)) begin
                        cur_chan <= cur_chan + 1'b1;
                        left     <= left - 1'b1;
                        state    <= S_SETTLE;
                    end else if (cont) begin
                        cur_chan <= first_chan;
                        left     <= scan ? LEFT_W'(BURST) : LEFT_W'(1);
                        state    <= S_SETTLE;
                    end else begin
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        conv_req |=> !conv_req);  // R9

    AST_CHAN_HELD_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT && !done) |=> $stable(cur_chan));  // R9
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int CW    = 3,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CW-1:0]    widx,
    input  logic [RES_W-1:0] wdata,
    input  logic [CW-1:0]    ridx,
    output logic [RES_W-1:0] rdata
);
    localparam int NUM = 1 << CW;

    logic [RES_W-1:0] mem [NUM];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM; i++) begin
            if (rst)                         mem[i] <= '0;
            else if (we && widx == CW'(i))   mem[i] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    output logic [7:0]       ctrl_rd,
    output logic [7:0]       cfg_rd,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [RES_W-1:0] rd_data,
    output logic [CH_W-1:0]  chan_sel,
    output logic             cclk_en,
    output logic             conv_req,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             busy
);
    ctrl_reg_t ctrl_q;
    cfg_reg_t  cfg_q;
    ctrl_reg_t wd;
    logic      wr_ctrl, wr_cfg, go, settling, store, seq_end;

    assign wd      = ctrl_reg_t'(wr_data);
    assign wr_ctrl = wr_en && !wr_sel;
    assign wr_cfg  = wr_en && wr_sel;
    assign go      = wr_ctrl && !busy && wd.start && cfg_q.enable;
    assign ctrl_rd = ctrl_q;
    assign cfg_rd  = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
        end else begin
            if (wr_cfg) begin
                cfg_q.enable <= wr_data[7];
                if (!cfg_q.enable) begin
                    cfg_q.div <= wr_data[2:0];
                    cfg_q.dly <= wr_data[5:3];
                end
            end
            if (!busy) begin
                if (wr_ctrl) begin
                    ctrl_q.chan  <= wd.chan;
                    ctrl_q.cont  <= wd.cont;
                    ctrl_q.scan  <= wd.scan;
                    ctrl_q.start <= go;
                end
            end else if (seq_end || (wr_ctrl && !wd.start)) begin
                ctrl_q.start <= 1'b0;
            end
        end
    end

    adc_clk_div #(.CNT_W(DIV_LOG2_MAX)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (settling),
        .log2 (div_log2(cfg_q.div)),
        .tick (cclk_en)
    );

    adc_seq_fsm #(.CW(CH_W), .BURST(BURST_LEN), .DCNT_W(DLY_LOG2_MAX)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .go          (go),
        .go_chan     (wd.chan),
        .go_scan     (wd.scan),
        .start       (ctrl_q.start),
        .cont        (ctrl_q.cont),
        .scan        (ctrl_q.scan),
        .first_chan  (ctrl_q.chan),
        .tick        (cclk_en),
        .settle_log2 (dly_log2(cfg_q.dly)),
        .done        (conv_done),
        .conv_req    (conv_req),
        .busy        (busy),
        .settling    (settling),
        .store       (store),
        .seq_end     (seq_end),
        .cur_chan    (chan_sel)
    );

    adc_result_bank #(.CW(CH_W), .RES_W(RES_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (store),
        .widx  (chan_sel),
        .wdata (conv_data),
        .ridx  (rd_chan),
        .rdata (rd_data)
    );

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.enable && wr_cfg) |=> ($stable(cfg_q.div) && $stable(cfg_q.dly)));  // R4

    AST_CONT_KEEPS_START: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.start && ctrl_q.cont && !wr_ctrl) |=> ctrl_q.start);  // R8

    AST_IDLE_CLEARS_START: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !ctrl_q.start);  // R6

    AST_FIELDS_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_ctrl) |=> ($stable(ctrl_q.chan) && $stable(ctrl_q.scan) && $stable(ctrl_q.cont)));  // R11
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] ctrl_rd, cfg_rd;
    logic [2:0] rd_chan = 3'd0, chan_sel;
    logic [9:0] rd_data, conv_data;
    logic       cclk_en, conv_req, conv_done, busy;
    logic       resp_done = 1'b0, spur_done = 1'b0;
    logic [9:0] resp_data = '0;

    assign conv_done = resp_done | spur_done;
    assign conv_data = spur_done ? 10'h3FF : resp_data;

    always #5 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl_rd(ctrl_rd), .cfg_rd(cfg_rd), .rd_chan(rd_chan), .rd_data(rd_data),
        .chan_sel(chan_sel), .cclk_en(cclk_en), .conv_req(conv_req),
        .conv_done(conv_done), .conv_data(conv_data), .busy(busy)
    );

    int n_chk = 0, n_bad = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_ph = 0;      // 0 idle, 1 settle, 2 request, 3 wait
    int         m_cnt = 0, m_left = 0;
    int         m_cur = 0;
    bit         m_start, m_scan, m_cont, m_en;
    int         m_chan, m_div, m_dly;
    logic [9:0] m_res [8];

    function automatic int span();
        int r = 1 << ((m_div > 5) ? 5 : m_div);
        int d = 1 << ((m_dly > 6) ? 6 : m_dly);
        return r * d;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_left = 0; m_cur = 0;
            m_start = 0; m_scan = 0; m_cont = 0; m_en = 0;
            m_chan = 0; m_div = 0; m_dly = 0;
            for (int i = 0; i < 8; i++) m_res[i] = '0;
        end else begin
            bit wc, wg, go, endseq, was_idle;
            wc = wr_en && !wr_sel;
            wg = wr_en && wr_sel;
            was_idle = (m_ph == 0);
            go = wc && was_idle && wr_data[7] && m_en;
            endseq = 0;
            case (m_ph)
                0: if (go) begin
                    m_cur = wr_data[2:0]; m_left = wr_data[5] ? 4 : 1;
                    m_cnt = span(); m_ph = 1;
                end
                1: begin m_cnt--; if (m_cnt == 0) m_ph = 2; end
                2: m_ph = 3;
                default: if (conv_done) begin
                    m_res[m_cur] = conv_data;
                    if (!m_start) begin m_ph = 0; endseq = 1; end
                    else if (m_left > 1) begin
                        m_cur = (m_cur + 1) % 8; m_left--; m_cnt = span(); m_ph = 1;
                    end else if (m_cont) begin
                        m_cur = m_chan; m_left = m_scan ? 4 : 1; m_cnt = span(); m_ph = 1;
                    end else begin m_ph = 0; endseq = 1; end
                end
            endcase
            if (wg) begin
                if (!m_en) begin m_div = wr_data[2:0]; m_dly = wr_data[5:3]; end
                m_en = wr_data[7];
            end
            if (was_idle) begin
                if (wc) begin
                    m_chan = wr_data[2:0]; m_cont = wr_data[4]; m_scan = wr_data[5];
                    m_start = go;
                end
            end else if (endseq || (wc && !wr_data[7])) m_start = 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check("R9 conv_req", 32'(conv_req), 32'(m_ph == 2));
            if (m_ph == 2) check("R7 chan_sel", 32'(chan_sel), 32'(m_cur));
            check("R6 busy", 32'(busy), 32'(m_ph != 0));
            check("R2 ctrl_rd", 32'(ctrl_rd),
                  32'({m_start, 1'b0, m_scan, m_cont, 1'b0, 3'(m_chan)}));
            check("R3 cfg_rd", 32'(cfg_rd), 32'({m_en, 1'b0, 3'(m_dly), 3'(m_div)}));
            check("R10 rd_data", 32'(rd_data), 32'(m_res[rd_chan]));
        end
    end

    // ---------------- converter responder ----------------
    int         n_req = 0;
    logic [2:0] seen_q[$];
    logic [9:0] last_res [8];

    initial begin
        forever begin
            @(negedge clk);
            if (conv_req) begin
                logic [2:0] ch;
                ch = chan_sel;
                n_req++;
                seen_q.push_back(ch);
                repeat (3) @(negedge clk);
                resp_data = {ch, 7'(n_req)};
                last_res[ch] = resp_data;
                resp_done = 1'b1;
                @(negedge clk);
                resp_done = 1'b0;
            end
        end
    end

    // ---------------- watchdog ----------------
    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        check("R6 sequence ends", 32'(busy), 32'd0);
    endtask

    task automatic latency(input string tag, input int exp);
        int c = 0;
        while (!conv_req && c < 5000) begin @(negedge clk); c++; end
        check(tag, 32'(c), 32'(exp));
    endtask

    task automatic read_res(input string tag, input logic [2:0] ch);
        rd_chan = ch;
        @(negedge clk);
        check(tag, 32'(rd_data), 32'(last_res[ch]));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ctrl reset", 32'(ctrl_rd), 32'h00);
        check("R1 cfg reset", 32'(cfg_rd), 32'h00);
        check("R1 busy reset", 32'(busy), 32'd0);
        check("R1 req reset", 32'(conv_req), 32'd0);

        // start with enable off; reserved bits read 0
        wr(1'b0, 8'hFF);
        check("R5 no start when disabled", 32'(ctrl_rd), 32'h37);
        check("R5 not busy", 32'(busy), 32'd0);
        wr(1'b1, 8'h7F);
        check("R3 cfg bit6 reads 0", 32'(cfg_rd), 32'h3F);
        wr(1'b1, 8'h11);
        wr(1'b1, 8'h91);
        check("R3 cfg enabled", 32'(cfg_rd), 32'h91);
        wr(1'b1, 8'hBF);
        check("R4 cfg locked", 32'(cfg_rd), 32'h91);

        // single conversion, ratio 2 x 4 settle periods
        wr(1'b0, 8'h84);
        latency("R3 first request latency", 8);
        wait_idle();
        check("R6 START cleared", 32'(ctrl_rd), 32'h04);
        read_res("R10 result ch4", 3'd4);

        // single with spurious done during settling
        wr(1'b0, 8'h85);
        @(negedge clk); spur_done = 1'b1;
        @(negedge clk); spur_done = 1'b0;
        wait_idle();
        read_res("R9 spurious done ignored", 3'd5);

        // scan from channel 6 with a field-changing write while busy
        seen_q.delete();
        wr(1'b0, 8'hA6);
        repeat (3) @(negedge clk);
        wr(1'b0, 8'hB1);
        check("R11 fields held while busy", 32'(ctrl_rd), 32'hA6);
        wait_idle();
        check("R7 burst length", 32'(seen_q.size()), 32'd4);
        if (seen_q.size() == 4) begin
            check("R7 order 0", 32'(seen_q[0]), 32'd6);
            check("R7 order 1", 32'(seen_q[1]), 32'd7);
            check("R7 order 2", 32'(seen_q[2]), 32'd0);
            check("R7 order 3", 32'(seen_q[3]), 32'd1);
        end
        read_res("R10 result ch7", 3'd7);
        read_res("R10 result ch0", 3'd0);

        // continuous single channel, then stop
        seen_q.delete();
        wr(1'b0, 8'h92);
        while (seen_q.size() < 3) @(negedge clk);
        check("R8 START held in continuous", 32'(ctrl_rd[7]), 32'd1);
        check("R8 still busy", 32'(busy), 32'd1);
        wr(1'b0, 8'h12);
        wait_idle();
        check("R8 stopped cleanly", 32'(ctrl_rd), 32'h12);
        read_res("R10 result ch2", 3'd2);

        // reserved divider code clamps to ratio 32, settle code 0
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h87);
        check("R3 cfg reload", 32'(cfg_rd), 32'h87);
        wr(1'b0, 8'h83);
        latency("R3 clamped divider latency", 32);
        wait_idle();
        read_res("R10 result ch3", 3'd3);

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule